// File: doc/BRIEF.md
# Four-Bank SDRAM Device Command Model

This block is the device side of a synchronous DRAM with four banks, written as a synthesizable model that a memory controller can be run against. On every rising clock edge with the clock enable high it samples the command strobes, bank and address inputs and byte masks. It decodes the command and keeps an open-row record for each bank. It also holds the programmed burst length and CAS latency.

Reads and writes are bursts. The model steps the column itself on each clock, wrapping inside a block aligned to the burst length. It returns read data after the programmed latency and applies the byte masks with the timing a real device uses. The stored words cover every bank and every column, but only the low row-address bits. A one-cycle error flag reports commands that a correct controller must never issue. Such commands are otherwise ignored.

Top module: `sdram_cmd_dev`

## Requirements
- R1: Commands are decoded as {cs_n,ras_n,cas_n,we_n}: 0011 open row, 0101 read, 0100 write, 0110 burst stop, 0010 close, 0000 mode load, 0111 no-op. With cs_n high nothing changes, and cmd_err is low in the following cycle. After reset all banks are closed, burst length is 1, CAS latency is 2, and dq_oe, dq_out and cmd_err are zero.
- R2: The open-row command records the row from addr in bank ba and marks that bank open. An open-row command to a bank that is already open is flagged and leaves the bank's row unchanged.
- R3: A read or write to a closed bank is flagged and ignored. A mode load while any bank is open is flagged and leaves the mode unchanged.
- R4: The mode load takes the burst length from addr[2:0] (0→1, 1→2, 2→4, 3→8, 7→full 256-column page, other codes→1) and the CAS latency from addr[6:4] (3 selects 3, any other value selects 2).
- R5: The data for a read column registered at edge k is driven from just after edge k+CL-1, so it is valid at edge k+CL. Both lanes are enabled for one cycle per column of the burst.
- R6: The column starts at addr[7:0] and advances by one on each clock of the burst, wrapping inside the block aligned to the burst length. A full-page burst wraps at 256 and runs until it is stopped.
- R7: Write data is taken at the edge of the write command and at each following burst edge. A lane whose dqm bit (bit 0 = dq[7:0], bit 1 = dq[15:8]) is high at that edge is not stored.
- R8: During a read, a dqm bit sampled high at edge j turns that lane off (dq_oe low, dq_out lane zero) for the data that is valid at edge j+2.
- R9: A burst stop ends the burst at its own edge: no column is accessed at that edge or later. Read data already in flight still appears.
- R10: A read or write issued during a burst replaces it and restarts at the new column.
- R11: addr[10] high on a read or write closes the bank after the burst's last column. A close command with addr[10] high closes all banks; with addr[10] low it closes bank ba. A close that hits the bank in burst ends the burst.
- R12: cmd_err is high for exactly the one cycle after the edge that registered a flagged command.
- R13: While cke is low, edges are ignored and all outputs and state hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low power-up reset |
| cke | input | 1 | Clock enable; low freezes the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | ROW_W (12) | Row, column, auto-close bit 10, or mode op-code |
| dqm | input | 2 | Byte masks, bit 0 low lane |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, zero in disabled lanes |
| dq_oe | output | 2 | Per-lane output enable |
| cmd_err | output | 1 | Illegal command seen at the previous edge |

## Verification
Inputs change on the falling edge and outputs are read on the following falling edge, so each check sees what the design shows just after the edge that took its input. cmd_err belongs to the edge that took the command. Read data for a column taken at edge k is checked after edge k+CL-1, so with a CAS latency of 3 the check comes two stimulus steps after the read. A read mask sampled at edge j is checked after edge j+1, against the word valid at edge j+2. The vector table puts each expected word in the row whose stimulus edge makes it visible. The directed tests count steps the same way for full-page wrap, burst stop, interruption, clock-enable freeze and bank closes.

// File: rtl/sdram_cmd_dev.sv
module sdram_cmd_dev #(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 8,
  parameter int ROW_KEEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [1:0]       ba,
  input  logic [ROW_W-1:0] addr,
  input  logic [1:0]       dqm,
  input  logic [15:0]      dq_in,
  output logic [15:0]      dq_out,
  output logic [1:0]       dq_oe,
  output logic             cmd_err
);
  localparam int NBANK  = 4;
  localparam int MEM_AW = 2 + ROW_KEEP + COL_W;
  localparam int DEPTH  = 1 << MEM_AW;
  localparam int APB    = 10;

  logic [15:0] mem [DEPTH];
  logic [NBANK-1:0] open_q;
  logic [ROW_KEEP-1:0] row_q [NBANK];
  logic [2:0] bl_code_q;
  logic cl3_q;
  logic b_on, b_wr, b_ap;
  logic [1:0] b_bank;
  logic [COL_W-1:0] b_start, b_cnt;
  logic [2:0] pv;
  logic [15:0] pd [3];
  logic [1:0] mq0, mq1;

  wire [3:0] cmd   = {cs_n, ras_n, cas_n, we_n};
  wire c_act = cmd == 4'b0011;
  wire c_rd  = cmd == 4'b0101;
  wire c_wr  = cmd == 4'b0100;
  wire c_bst = cmd == 4'b0110;
  wire c_pre = cmd == 4'b0010;
  wire c_lmr = cmd == 4'b0000;

  logic [COL_W-1:0] wrap_m;
  always_comb begin
    case (bl_code_q)
      3'd1:    wrap_m = COL_W'(1);
      3'd2:    wrap_m = COL_W'(3);
      3'd3:    wrap_m = COL_W'(7);
      3'd7:    wrap_m = '1;
      default: wrap_m = '0;
    endcase
  end
  wire full_pg = bl_code_q == 3'd7;

  wire rw_ok   = (c_rd | c_wr) & open_q[ba];
  wire err_now = ((c_rd | c_wr) & ~open_q[ba]) | (c_act & open_q[ba]) | (c_lmr & |open_q);
  wire pre_hit = c_pre & (addr[APB] | (ba == b_bank));
  wire cont    = b_on & ~rw_ok & ~c_bst & ~pre_hit;
  wire acc     = rw_ok | cont;

  wire [COL_W-1:0] nxt_col = (b_start & ~wrap_m) | ((b_start + b_cnt) & wrap_m);
  wire             acc_wr   = rw_ok ? c_wr : b_wr;
  wire [1:0]       acc_bank = rw_ok ? ba : b_bank;
  wire [COL_W-1:0] acc_col  = rw_ok ? addr[COL_W-1:0] : nxt_col;
  wire             acc_ap   = rw_ok ? addr[APB] : b_ap;
  wire [COL_W-1:0] new_cnt  = rw_ok ? COL_W'(1) : b_cnt + COL_W'(1);
  wire last = ~full_pg & ({1'b0, new_cnt} == ({1'b0, wrap_m} + 1'b1));
  wire [MEM_AW-1:0] ma = {acc_bank, row_q[acc_bank], acc_col};

  logic unused_bits;
  assign unused_bits = ^{addr[ROW_W-1], addr[9:8], addr[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int i = 0; i < NBANK; i++) row_q[i] <= '0;
      bl_code_q <= '0;
      cl3_q <= 1'b0;
      b_on <= 1'b0; b_wr <= 1'b0; b_ap <= 1'b0;
      b_bank <= '0; b_start <= '0; b_cnt <= '0;
      cmd_err <= 1'b0;
    end else if (cke) begin
      cmd_err <= err_now;
      if (c_lmr && !(|open_q)) begin
        bl_code_q <= addr[2:0];
        cl3_q <= addr[6:4] == 3'd3;
      end
      if (c_act && !open_q[ba]) begin
        open_q[ba] <= 1'b1;
        row_q[ba] <= addr[ROW_KEEP-1:0];
      end
      if (c_pre) begin
        if (addr[APB]) open_q <= '0;
        else open_q[ba] <= 1'b0;
      end
      if (acc && last && acc_ap) open_q[acc_bank] <= 1'b0;
      if (rw_ok) begin
        b_wr <= c_wr; b_ap <= addr[APB];
        b_bank <= ba; b_start <= addr[COL_W-1:0];
      end
      if (acc) begin
        b_cnt <= new_cnt;
        b_on <= ~last;
      end else if (b_on) begin
        b_on <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cke && acc && acc_wr) begin
      if (!dqm[0]) mem[ma][7:0]  <= dq_in[7:0];
      if (!dqm[1]) mem[ma][15:8] <= dq_in[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < 3; i++) pd[i] <= '0;
      mq0 <= 2'b11; mq1 <= 2'b11;
    end else if (cke) begin
      pv <= {pv[1:0], acc & ~acc_wr};
      pd[0] <= mem[ma];
      pd[1] <= pd[0];
      pd[2] <= pd[1];
      mq0 <= dqm;
      mq1 <= mq0;
    end
  end

  wire        v_sel = cl3_q ? pv[2] : pv[1];
  wire [15:0] d_sel = cl3_q ? pd[2] : pd[1];
  assign dq_oe  = {2{v_sel}} & ~mq1;
  assign dq_out = d_sel & {{8{dq_oe[1]}}, {8{dq_oe[0]}}};
endmodule

// File: rtl/sdram_cmd_dev_chk.sv
module sdram_cmd_dev_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic        cs_n,
  input logic [1:0]  dqm,
  input logic [15:0] dq_out,
  input logic [1:0]  dq_oe,
  input logic        cmd_err
);
  a_r13_cke_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(dq_oe) && $stable(dq_out) && $stable(cmd_err)));

  a_r1_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n) |=> !cmd_err);

  a_r12_err_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> ($past(cke) && !$past(cs_n)));

  a_r8_mask_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && $past(cke, 2) && dq_oe[0]) |-> !$past(dqm[0], 2));

  a_r8_mask_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke) && $past(cke, 2) && dq_oe[1]) |-> !$past(dqm[1], 2));
endmodule

bind sdram_cmd_dev sdram_cmd_dev_chk u_chk (.*);

// File: tb/sdram_cmd_dev_bench.sv
module sdram_cmd_dev_bench;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         BST = 4'b0110, PRE = 4'b0010, LMR = 4'b0000, INH = 4'b1000;

  typedef struct packed {
    logic [3:0] c; logic [1:0] b; logic [11:0] a; logic [1:0] m; logic [15:0] d;
    logic [1:0] eoe; logic [15:0] eq; logic ee;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t TBL [NV] = '{
    '{LMR, 2'd0, 12'h022, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{ACT, 2'd0, 12'h001, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{WR,  2'd0, 12'h010, 2'b00, 16'hA000, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hA001, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hA002, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hA003, 2'b00, 16'h0000, 1'b0},
    '{RD,  2'd0, 12'h012, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hA002, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hA003, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hA000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hA001, 1'b0},
    '{RD,  2'd0, 12'h010, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b10, 16'h0000, 2'b11, 16'hA000, 1'b0},
    '{BST, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b01, 16'h0001, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{RD,  2'd1, 12'h000, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{ACT, 2'd0, 12'h005, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{PRE, 2'd0, 12'h400, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{RD,  2'd0, 12'h010, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{INH, 2'd0, 12'h027, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{LMR, 2'd0, 12'h033, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{ACT, 2'd2, 12'h000, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{WR,  2'd2, 12'h4FE, 2'b00, 16'hB0FE, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hB0FF, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hB0F8, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hB0F9, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hB0FA, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hB0FB, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hB0FC, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'hB0FD, 2'b00, 16'h0000, 1'b0},
    '{RD,  2'd2, 12'h0F8, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b1},
    '{ACT, 2'd2, 12'h000, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{RD,  2'd2, 12'h0F8, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hB0F8, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hB0F9, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hB0FA, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hB0FB, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hB0FC, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hB0FD, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hB0FE, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b11, 16'hB0FF, 1'b0},
    '{NOP, 2'd0, 12'h000, 2'b00, 16'h0000, 2'b00, 16'h0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0, dqm = '0;
  logic [11:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0] dq_oe;
  logic cmd_err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_dev u_sdram_cmd_dev (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .cmd_err(cmd_err)
  );

  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a,
                      input logic [1:0] m, input logic [15:0] d);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; addr = a; dqm = m; dq_in = d;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] eoe, input logic [15:0] eq,
                     input logic ee);
    checks++;
    if (dq_oe !== eoe || dq_out !== eq || cmd_err !== ee) begin
      fails++;
      $display("FAIL %s: oe=%b dout=%h err=%b expected oe=%b dout=%h err=%b",
               req, dq_oe, dq_out, cmd_err, eoe, eq, ee);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", 2'b00, 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table: R1 R2 R3 R4 R5 R6 R8 R9 R11 R12 across one trace
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].c, TBL[i].b, TBL[i].a, TBL[i].m, TBL[i].d);
      chk($sformatf("R5/R6/R8/R11/R12 table row %0d", i), TBL[i].eoe, TBL[i].eq, TBL[i].ee);
    end

    // R7 byte mask on write, R4 burst length 1
    step(PRE, 2'd0, 12'h400, 2'b00, 16'h0);
    step(LMR, 2'd0, 12'h020, 2'b00, 16'h0);
    chk("R4 mode load accepted", 2'b00, 16'h0000, 1'b0);
    step(ACT, 2'd3, 12'h000, 2'b00, 16'h0);
    step(WR,  2'd3, 12'h005, 2'b00, 16'h1234);
    step(WR,  2'd3, 12'h005, 2'b01, 16'hABCD);
    step(RD,  2'd3, 12'h005, 2'b00, 16'h0);
    chk("R5 no data before latency", 2'b00, 16'h0000, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R7 masked low lane kept", 2'b11, 16'hAB34, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R5 burst of one ends", 2'b00, 16'h0000, 1'b0);

    // R6 full page wrap, R9 burst stop on write and read
    step(PRE, 2'd0, 12'h400, 2'b00, 16'h0);
    step(LMR, 2'd0, 12'h027, 2'b00, 16'h0);
    step(ACT, 2'd3, 12'h000, 2'b00, 16'h0);
    step(WR,  2'd3, 12'h001, 2'b00, 16'h5555);
    step(BST, 2'd0, 12'h000, 2'b00, 16'h0);
    step(WR,  2'd3, 12'h0FE, 2'b00, 16'h0001);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0002);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0003);
    step(BST, 2'd0, 12'h000, 2'b00, 16'h0004);
    step(RD,  2'd3, 12'h0FE, 2'b00, 16'h0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R6 page col FE", 2'b11, 16'h0001, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R6 page col FF", 2'b11, 16'h0002, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R6 page wraps to col 00", 2'b11, 16'h0003, 1'b0);
    step(BST, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R9 write stop left col 01", 2'b11, 16'h5555, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R9 read stopped", 2'b00, 16'h0000, 1'b0);

    // R10 interrupting read
    step(RD,  2'd3, 12'h0FF, 2'b00, 16'h0);
    step(RD,  2'd3, 12'h0FE, 2'b00, 16'h0);
    chk("R10 first column", 2'b11, 16'h0002, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R10 restarted at FE", 2'b11, 16'h0001, 1'b0);
    step(BST, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R10 continues to FF", 2'b11, 16'h0002, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);

    // R13 clock enable freeze
    step(RD,  2'd3, 12'h0FE, 2'b00, 16'h0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R13 before freeze", 2'b11, 16'h0001, 1'b0);
    cke = 1'b0;
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R13 frozen 1", 2'b11, 16'h0001, 1'b0);
    step(ACT, 2'd3, 12'h000, 2'b00, 16'h0);
    chk("R13 frozen 2 ignores command", 2'b11, 16'h0001, 1'b0);
    cke = 1'b1;
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R13 resumes", 2'b11, 16'h0002, 1'b0);
    step(BST, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R13 resumed column 00", 2'b11, 16'h0003, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);

    // R11 single-bank close and close ending a burst
    step(ACT, 2'd1, 12'h000, 2'b00, 16'h0);
    chk("R2 open bank 1", 2'b00, 16'h0000, 1'b0);
    step(PRE, 2'd1, 12'h000, 2'b00, 16'h0);
    step(RD,  2'd1, 12'h000, 2'b00, 16'h0);
    chk("R11 bank 1 closed", 2'b00, 16'h0000, 1'b1);
    step(RD,  2'd3, 12'h0FE, 2'b00, 16'h0);
    chk("R11 bank 3 still open", 2'b00, 16'h0000, 1'b0);
    step(PRE, 2'd3, 12'h000, 2'b00, 16'h0);
    chk("R11 data before close", 2'b11, 16'h0001, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R11 close ended burst", 2'b00, 16'h0000, 1'b0);
    step(RD,  2'd3, 12'h0FE, 2'b00, 16'h0);
    chk("R11 bank 3 now closed", 2'b00, 16'h0000, 1'b1);

    // R3 mode load refused while a bank is open
    step(ACT, 2'd3, 12'h000, 2'b00, 16'h0);
    step(LMR, 2'd0, 12'h032, 2'b00, 16'h0);
    chk("R3 mode load flagged", 2'b00, 16'h0000, 1'b1);
    step(RD,  2'd3, 12'h0FE, 2'b00, 16'h0);
    chk("R12 flag lasts one cycle", 2'b00, 16'h0000, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R3 latency still 2", 2'b11, 16'h0001, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R3 burst still full page", 2'b11, 16'h0002, 1'b0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);
    chk("R3 page continues", 2'b11, 16'h0003, 1'b0);
    step(BST, 2'd0, 12'h000, 2'b00, 16'h0);
    step(NOP, 2'd0, 12'h000, 2'b00, 16'h0);

    summary();
  end
endmodule